// File: doc/BRIEF.md
# Variable-Latency DDR PSRAM Controller

This block sits between a single-word request port and an 8-bit double-data-rate pseudo-static RAM of 64 Mbit. Each request moves one 16-bit word, two bytes on the two edges of one memory clock. The block selects the device and sends a 48-bit command/address over three clocks. It then waits out the initial latency and moves the data word. After that it deselects the device for at least one clock.

The device can be busy refreshing when a transaction opens. It signals this by holding its read-write strobe high during the command phase. The controller then doubles the initial latency, for writes and for reads alike. Every completed request reports which latency was used.

All outgoing pins leave through a chain of output registers that models the DDR output cells, three stages deep by default. The strobe sample point and the read capture window are placed in pin time, so they stay aligned whatever the depth. After reset the block waits a fixed startup interval. It then writes the device configuration register, which selects the latency count and variable-latency mode, and only then accepts requests.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is held, ram_cs_n is 1, ram_ck is 2'b00, ram_ck_n is 2'b11, ram_dq_oe, done and ready are 0.
- R2: ready stays 0 for at least STARTUP_CYC cycles after reset and once set never falls. Requests offered before ready are ignored. The first transaction is a configuration write. Its command word has bit 47 = 0 and bit 46 = 1, with the address field built from CFG_ADDR as in R3. Its data word {8'h8F, code, 1'b0, 3'b111} is on the pins in the clock right after the three command clocks, with no latency. code is 4'hE for LAT = 3 and 4'hF for LAT = 4.
- R3: For a request, command bit 47 is 1 for read and 0 for write, bit 46 = 0 and bit 45 = 1. Bits 44:16 hold word address bits above bit 2, bits 15:3 are 0 and bits 2:0 hold word address bits 2:0. The command is sent high 16 bits first, one 16-bit beat per clock, with ram_dq_o[15:8] on the first edge.
- R4: If ram_rwds_i is low in the second command clock as seen at the pins, the data clock is pin clock 3+LAT. Pin clock 0 is the first clock with ram_cs_n low.
- R5: If ram_rwds_i is high in that clock, the data clock is pin clock 3+2*LAT.
- R6: Each request ends with done high for exactly one cycle. done_2x is 1 if the doubled latency was used and 0 otherwise.
- R7: In the write data clock, ram_dq_o carries the request word with ram_dq_oe = 1, ram_rwds_oe = 1 and ram_rwds_o = 0. ram_dq_oe is 0 in every other clock after the command phase, and for reads throughout.
- R8: A read captures ram_dq_i in the first clock, at or after its data clock, in which ram_rwds_i is high. That word is presented on rdata together with done.
- R9: busy is 1 from the cycle after a request is accepted through the done cycle and 0 the cycle after. Requests offered while busy are ignored, so each accepted request yields exactly one chip-select period.
- R10: ram_cs_n is high for at least one clock between transactions. While ram_cs_n is high the clock pair rests at ram_ck = 2'b00 and ram_ck_n = 2'b11, and ram_ck_n is always the bitwise complement of ram_ck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one memory clock per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write word, bits 15:8 go first |
| ready | output | 1 | Startup and configuration complete |
| busy | output | 1 | A transaction or startup is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_2x | output | 1 | Doubled latency was used, valid with done |
| rdata | output | 16 | Read word, valid with done |
| ram_cs_n | output | 1 | Chip select, active low |
| ram_ck | output | 2 | Clock, {first half, second half} |
| ram_ck_n | output | 2 | Complement clock, driven explicitly |
| ram_dq_o | output | 16 | Outgoing bytes, bits 15:8 on the first edge |
| ram_dq_oe | output | 1 | Data bus drive enable |
| ram_dq_i | input | 16 | Incoming bytes captured on both strobe edges |
| ram_rwds_o | output | 1 | Outgoing strobe level |
| ram_rwds_oe | output | 1 | Strobe drive enable |
| ram_rwds_i | input | 1 | Strobe from the device, sampled directly |

## Verification
A bench-side device model replies to the pins. It holds the strobe high or low in the command phase, records every chip-select period and returns an address-derived word on reads. Writes and reads are swept over eight addresses with the strobe in both states. The addresses are zero, all ones, alternating bits, and values that cross the bit-2/bit-3 split of the address field. The two strobe levels tell apart the single and doubled data clocks, and the addresses expose any mis-packed command field. A request offered during startup and another offered mid-transaction must leave no extra chip-select period. Back-to-back requests check the deselect gap and the resting clock pair.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int WORD_W = 16;
    localparam int CA_W   = 48;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_CMD,
        ST_WAIT,
        ST_WDATA,
        ST_RDATA,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic              cs_n;
        logic [1:0]        ck;
        logic [1:0]        ck_n;
        logic [WORD_W-1:0] dq;
        logic              dq_oe;
        logic              rwds;
        logic              rwds_oe;
    } pin_bundle_t;

    localparam pin_bundle_t PIN_IDLE = '{
        cs_n: 1'b1, ck: 2'b00, ck_n: 2'b11, dq: '0,
        dq_oe: 1'b0, rwds: 1'b0, rwds_oe: 1'b0
    };

    function automatic logic [CA_W-1:0] build_ca(input logic rd, input logic regs,
                                                 input logic [31:0] waddr);
        return {rd, regs, 1'b1, waddr[31:3], 13'd0, waddr[2:0]};
    endfunction

    function automatic logic [WORD_W-1:0] build_cfg(input int lat);
        logic [3:0] code;
        code = (lat == 3) ? 4'hE : 4'hF;
        return {8'h8F, code, 1'b0, 3'b111};
    endfunction

endpackage

// File: rtl/psram_startup.sv
module psram_startup #(
    parameter int STARTUP_CYC = 15000
) (
    input  logic clk,
    input  logic rst_n,
    output logic start_done
);
    localparam int TW = $clog2(STARTUP_CYC + 1) + 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          done;
    } tmr_t;

    tmr_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!r_q.done) begin
            if (int'(r_q.cnt) >= STARTUP_CYC - 1) begin
                r_d.done = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign start_done = r_q.done;

    assert_start_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |=> start_done);

endmodule

// File: rtl/psram_out_pipe.sv
module psram_out_pipe
    import psram_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  pin_bundle_t in_pins,
    output pin_bundle_t out_pins
);
    pin_bundle_t stg_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        pin_bundle_t stg_d;
        if (i == 0) begin : g_first
            assign stg_d = in_pins;
        end else begin : g_next
            assign stg_d = stg_q[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[i] <= PIN_IDLE;
            end else begin
                stg_q[i] <= stg_d;
            end
        end
    end

    assign out_pins = stg_q[DEPTH-1];

    assert_ck_compl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_pins.ck_n == ~out_pins.ck);

    assert_rest_clock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_pins.cs_n |-> (out_pins.ck == 2'b00));

    assert_strobe_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_pins.rwds_oe |-> (out_pins.dq_oe && !out_pins.rwds && !out_pins.cs_n));

endmodule

// File: rtl/psram_seq.sv
module psram_seq
    import psram_pkg::*;
#(
    parameter int          ADDR_W   = 22,
    parameter int          LAT      = 3,
    parameter int          OUT_DLY  = 3,
    parameter logic [31:0] CFG_ADDR = 32'h0000_0800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_done,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [WORD_W-1:0] rd_word,
    input  logic              strobe_in,
    output logic              ready,
    output logic              busy,
    output logic              done,
    output logic              done_2x,
    output logic [WORD_W-1:0] rdata,
    output pin_bundle_t       issue
);
    localparam int LAT1    = LAT;
    localparam int LAT2    = 2 * LAT;
    localparam int SAMP_AT = OUT_DLY + 1;
    localparam int CNT_MAX = 3 + LAT2 + OUT_DLY + 2;
    localparam int CNT_W   = $clog2(CNT_MAX + 1) + 1;

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [CA_W-1:0]   ca;
        logic [WORD_W-1:0] wdata;
        logic              is_rd;
        logic              is_cfg;
        logic              lat2x;
        logic [WORD_W-1:0] rdata;
        logic              done;
        logic              ready;
    } seq_t;

    seq_t r_q, r_d;

    logic active;
    logic samp_now;
    logic lat_now;
    int   w_cyc;
    int   wait_last;
    int   rd_first;

    always_comb begin
        active    = (r_q.state == ST_CMD) || (r_q.state == ST_WAIT) ||
                    (r_q.state == ST_WDATA) || (r_q.state == ST_RDATA);
        samp_now  = active && (int'(r_q.cnt) == SAMP_AT);
        lat_now   = samp_now ? strobe_in : r_q.lat2x;
        w_cyc     = lat_now ? LAT2 : LAT1;
        wait_last = 2 + w_cyc;
        rd_first  = 3 + (r_q.lat2x ? LAT2 : LAT1) + OUT_DLY;

        r_d      = r_q;
        r_d.done = 1'b0;

        if (active && (r_q.cnt != '1)) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
        if (samp_now && !r_q.is_cfg) begin
            r_d.lat2x = strobe_in;
        end

        unique case (r_q.state)
            ST_BOOT: begin
                if (start_done) begin
                    r_d.state  = ST_CMD;
                    r_d.cnt    = '0;
                    r_d.is_cfg = 1'b1;
                    r_d.is_rd  = 1'b0;
                    r_d.ca     = build_ca(1'b0, 1'b1, CFG_ADDR);
                    r_d.wdata  = build_cfg(LAT);
                end
            end
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state  = ST_CMD;
                    r_d.cnt    = '0;
                    r_d.is_cfg = 1'b0;
                    r_d.is_rd  = !req_write;
                    r_d.lat2x  = 1'b0;
                    r_d.ca     = build_ca(!req_write, 1'b0, 32'(req_addr));
                    r_d.wdata  = req_wdata;
                end
            end
            ST_CMD: begin
                if (int'(r_q.cnt) == 2) begin
                    r_d.state = r_q.is_cfg ? ST_WDATA : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (int'(r_q.cnt) == wait_last) begin
                    r_d.state = r_q.is_rd ? ST_RDATA : ST_WDATA;
                end
            end
            ST_WDATA: begin
                r_d.state = ST_GAP;
                if (r_q.is_cfg) begin
                    r_d.ready = 1'b1;
                end else begin
                    r_d.done = 1'b1;
                end
            end
            ST_RDATA: begin
                if ((int'(r_q.cnt) >= rd_first) && strobe_in) begin
                    r_d.rdata = rd_word;
                    r_d.done  = 1'b1;
                    r_d.state = ST_GAP;
                end
            end
            ST_GAP: begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_BOOT;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        issue = PIN_IDLE;
        if (active) begin
            issue.cs_n = 1'b0;
            issue.ck   = 2'b10;
            issue.ck_n = 2'b01;
        end
        if (r_q.state == ST_CMD) begin
            issue.dq_oe = 1'b1;
            unique case (r_q.cnt[1:0])
                2'd0:    issue.dq = r_q.ca[47:32];
                2'd1:    issue.dq = r_q.ca[31:16];
                default: issue.dq = r_q.ca[15:0];
            endcase
        end
        if (r_q.state == ST_WDATA) begin
            issue.dq      = r_q.wdata;
            issue.dq_oe   = 1'b1;
            issue.rwds    = 1'b0;
            issue.rwds_oe = 1'b1;
        end
    end

    assign ready   = r_q.ready;
    assign busy    = (r_q.state != ST_IDLE);
    assign done    = r_q.done;
    assign done_2x = r_q.lat2x;
    assign rdata   = r_q.rdata;

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && ready));

    assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    assert_ready_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> start_done);

    assert_lat_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == ST_RDATA) && $past(r_q.state == ST_RDATA)) |-> $stable(r_q.lat2x));

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int          ADDR_W      = 22,
    parameter int          LAT         = 3,
    parameter int          OUT_DLY     = 3,
    parameter int          STARTUP_CYC = 15000,
    parameter logic [31:0] CFG_ADDR    = 32'h0000_0800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    output logic              ready,
    output logic              busy,
    output logic              done,
    output logic              done_2x,
    output logic [15:0]       rdata,
    output logic              ram_cs_n,
    output logic [1:0]        ram_ck,
    output logic [1:0]        ram_ck_n,
    output logic [15:0]       ram_dq_o,
    output logic              ram_dq_oe,
    input  logic [15:0]       ram_dq_i,
    output logic              ram_rwds_o,
    output logic              ram_rwds_oe,
    input  logic              ram_rwds_i
);
    logic        start_done;
    pin_bundle_t issue;
    pin_bundle_t pins;

    psram_startup #(
        .STARTUP_CYC(STARTUP_CYC)
    ) i_startup (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_done(start_done)
    );

    psram_seq #(
        .ADDR_W  (ADDR_W),
        .LAT     (LAT),
        .OUT_DLY (OUT_DLY),
        .CFG_ADDR(CFG_ADDR)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_done(start_done),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_word   (ram_dq_i),
        .strobe_in (ram_rwds_i),
        .ready     (ready),
        .busy      (busy),
        .done      (done),
        .done_2x   (done_2x),
        .rdata     (rdata),
        .issue     (issue)
    );

    psram_out_pipe #(
        .DEPTH(OUT_DLY)
    ) i_out_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_pins (issue),
        .out_pins(pins)
    );

    assign ram_cs_n    = pins.cs_n;
    assign ram_ck      = pins.ck;
    assign ram_ck_n    = pins.ck_n;
    assign ram_dq_o    = pins.dq;
    assign ram_dq_oe   = pins.dq_oe;
    assign ram_rwds_o  = pins.rwds;
    assign ram_rwds_oe = pins.rwds_oe;

    assert_no_start_before_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_done) |-> (ram_cs_n && !ready));

endmodule

// File: tb/test_psram_ctrl.sv
module test_psram_ctrl;
    localparam int ADDR_W  = 22;
    localparam int LAT     = 3;
    localparam int OUT_DLY = 3;
    localparam int STARTUP = 40;
    localparam logic [31:0] CFG_ADDR = 32'h0000_0800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic ready, busy, done, done_2x;
    logic [15:0] rdata;
    logic ram_cs_n;
    logic [1:0] ram_ck, ram_ck_n;
    logic [15:0] ram_dq_o;
    logic ram_dq_oe;
    logic [15:0] ram_dq_i = '0;
    logic ram_rwds_o, ram_rwds_oe;
    logic ram_rwds_i = 1'b0;

    always #2.5 clk = ~clk;

    psram_ctrl #(
        .ADDR_W(ADDR_W), .LAT(LAT), .OUT_DLY(OUT_DLY),
        .STARTUP_CYC(STARTUP), .CFG_ADDR(CFG_ADDR)
    ) i_psram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .busy(busy),
        .done(done), .done_2x(done_2x), .rdata(rdata), .ram_cs_n(ram_cs_n),
        .ram_ck(ram_ck), .ram_ck_n(ram_ck_n), .ram_dq_o(ram_dq_o),
        .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i), .ram_rwds_o(ram_rwds_o),
        .ram_rwds_oe(ram_rwds_oe), .ram_rwds_i(ram_rwds_i)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // device model, reacting to the pins at each falling edge
    bit          m_collide = 1'b1;
    bit          m_act = 0;
    int          m_beat = 0;
    int          m_w = 0;
    int          m_first = -1;
    logic [47:0] m_ca = '0;
    logic [15:0] m_wd = '0;
    bit          m_wstb = 0;
    int          m_cnt = 0;
    int          m_gap = 0;
    int          m_mingap = 1000;
    bit          m_clkerr = 0;
    bit          m_caerr = 0;
    logic [47:0] last_ca = '0;
    int          last_first = -1;
    logic [15:0] last_wd = '0;
    bit          last_wstb = 0;

    function automatic logic [15:0] pat(input logic [15:0] a);
        return a ^ 16'hA5C3;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_ck_n != ~ram_ck) m_clkerr = 1;
            if (!ram_cs_n) begin
                if (!m_act) begin
                    m_act = 1; m_beat = 0; m_first = -1; m_ca = '0;
                    m_wd = '0; m_wstb = 0;
                    ram_rwds_i = m_collide;
                    if (m_cnt > 0 && m_gap < m_mingap) m_mingap = m_gap;
                end else begin
                    m_beat++;
                end
                if (m_beat < 3) begin
                    if (!ram_dq_oe) m_caerr = 1;
                    m_ca = {m_ca[31:0], ram_dq_o};
                    if (m_beat == 2)
                        m_w = m_ca[46] ? 0 : (m_collide ? 2 * LAT : LAT);
                end else begin
                    if (m_beat == 3) ram_rwds_i = 1'b0;
                    if (ram_dq_oe && m_first < 0) begin
                        m_first = m_beat; m_wd = ram_dq_o;
                        m_wstb = ram_rwds_oe && !ram_rwds_o;
                    end
                    if (m_ca[47]) begin
                        if (m_beat == 3 + m_w) begin
                            ram_dq_i = pat({m_ca[28:16], m_ca[2:0]});
                            ram_rwds_i = 1'b1;
                        end
                        if (m_beat == 4 + m_w) begin
                            ram_dq_i = '0; ram_rwds_i = 1'b0;
                        end
                    end
                end
            end else begin
                if (m_act) begin
                    m_act = 0; m_cnt++; m_gap = 0;
                    last_ca = m_ca; last_first = m_first;
                    last_wd = m_wd; last_wstb = m_wstb;
                    ram_rwds_i = 1'b0; ram_dq_i = '0;
                end
                m_gap++;
                if (ram_ck != 2'b00 || ram_ck_n != 2'b11) m_clkerr = 1;
            end
        end
    end

    function automatic logic [47:0] exp_ca(input bit rd, input bit regs,
                                           input logic [31:0] a);
        logic [47:0] c;
        c = '0;
        c[47] = rd; c[46] = regs; c[45] = 1'b1;
        c[44:16] = a[31:3];
        c[2:0] = a[2:0];
        return c;
    endfunction

    task automatic run(input bit wr, input logic [ADDR_W-1:0] a,
                       input logic [15:0] wd, input bit col, input bit poke);
        int c0;
        int n;
        int expw;
        m_collide = col;
        c0 = m_cnt;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        chk(busy == 1, "R9 busy after accept", 64'(busy), 1);
        if (poke) begin
            req_valid = 1; req_write = 1; req_addr = ~a; req_wdata = ~wd;
            repeat (3) @(negedge clk);
            req_valid = 0;
        end
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk); n++;
        end
        chk(done == 1, "R6 done seen", 64'(done), 1);
        chk(done_2x == col, "R6 latency report", 64'(done_2x), 64'(col));
        if (!wr) chk(rdata == pat(a[15:0]), "R8 read word", 64'(rdata), 64'(pat(a[15:0])));
        @(negedge clk);
        chk(done == 0, "R6 single pulse", 64'(done), 0);
        chk(busy == 0, "R9 busy drop", 64'(busy), 0);
        repeat (OUT_DLY + 3) @(negedge clk);
        chk(m_cnt == c0 + 1, "R9 one transaction", 64'(m_cnt), 64'(c0 + 1));
        chk(last_ca == exp_ca(!wr, 1'b0, 32'(a)), "R3 command word", last_ca,
            exp_ca(!wr, 1'b0, 32'(a)));
        expw = col ? 2 * LAT : LAT;
        if (wr) begin
            chk(last_first == 3 + expw, col ? "R5 write data clock" : "R4 write data clock",
                64'(last_first), 64'(3 + expw));
            chk(last_wd == wd, "R7 write word", 64'(last_wd), 64'(wd));
            chk(last_wstb == 1, "R7 strobe driven low", 64'(last_wstb), 1);
        end else begin
            chk(last_first == -1, "R7 no drive on read", 64'(last_first), 64'hFFFFFFFF);
        end
    endtask

    logic [ADDR_W-1:0] addrs [8];

    initial begin
        addrs[0] = 22'h000000; addrs[1] = 22'h000001; addrs[2] = 22'h000007;
        addrs[3] = 22'h000008; addrs[4] = 22'h3FFFFF; addrs[5] = 22'h2AAAAA;
        addrs[6] = 22'h155555; addrs[7] = 22'h123456;
        repeat (3) @(negedge clk);
        chk(ram_cs_n == 1, "R1 cs idle", 64'(ram_cs_n), 1);
        chk(ram_ck == 2'b00 && ram_ck_n == 2'b11, "R1 clock pair", 64'({ram_ck, ram_ck_n}), 64'h3);
        chk(ram_dq_oe == 0 && done == 0 && ready == 0, "R1 outputs low",
            64'({ram_dq_oe, done, ready}), 0);
        rst_n = 1;
        req_valid = 1; req_write = 1; req_addr = 22'h000123; req_wdata = 16'h1111;
        repeat (STARTUP - 1) @(negedge clk);
        chk(ready == 0, "R2 ready held during startup", 64'(ready), 0);
        req_valid = 0;
        begin
            int n = 0;
            while (!ready && n < 500) begin @(negedge clk); n++; end
        end
        chk(ready == 1, "R2 ready rises", 64'(ready), 1);
        repeat (OUT_DLY + 3) @(negedge clk);
        chk(m_cnt == 1, "R2 only config write", 64'(m_cnt), 1);
        chk(last_ca == exp_ca(1'b0, 1'b1, CFG_ADDR), "R2 config command", last_ca,
            exp_ca(1'b0, 1'b1, CFG_ADDR));
        chk(last_wd == {8'h8F, (LAT == 3) ? 4'hE : 4'hF, 1'b0, 3'b111}, "R2 config word",
            64'(last_wd), 64'({8'h8F, (LAT == 3) ? 4'hE : 4'hF, 1'b0, 3'b111}));
        chk(last_first == 3, "R2 config no latency", 64'(last_first), 3);

        for (int col = 0; col < 2; col++) begin
            for (int i = 0; i < 8; i++) begin
                logic [15:0] wd;
                wd = 16'(i * 16'h1357) ^ 16'(col * 16'h8001);
                run(1'b1, addrs[i], wd, col[0], (i == 2));
                run(1'b0, addrs[i], 16'h0, col[0], (i == 5));
            end
        end
        chk(m_mingap >= 1, "R10 deselect gap", 64'(m_mingap), 1);
        chk(m_clkerr == 0, "R10 clock pair rest", 64'(m_clkerr), 0);
        chk(m_caerr == 0, "R3 command driven", 64'(m_caerr), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule